// File: doc/BRIEF.md
# Clock Generator Power-Down Sequencer

This controller places a clock generator into a low-power state and brings it back out again. An active-low power-down request arrives with no timing relation to the reference clock. The request first passes through a synchronizer. When it takes effect, the output-gate enables of every clock group fall together. The crystal oscillator enable and the VCO enable stay high for a programmable parking interval, so every output is already parked low before its source stops.

On release, both oscillators are re-enabled. The output gates stay closed for a programmable stabilization interval, counted in reference cycles, and only then reopen. While running, the CPU-group and PCI-group stop requests each close their own gate. Outside the running state these stop requests are ignored. The oscillators appear here only as enable signals. The gate enables drive glitch-free gating cells placed downstream. Every output is a flop, so an enable can only change at a reference edge.

Top module: `clkgen_pwrdn_seq`

## Requirements
- R1: Each request input is synchronized through SYNC_STAGES flops (default 2). A change on `pd_req_n` reaches the outputs on rising edge SYNC_STAGES+1 after the change is launched, and not before.
- R2: On power-down entry, all four gate enables (`cpu_clk_en`, `pci_clk_en`, `free_clk_en`, `ref_clk_en`) fall on the same edge. `xtal_en` and `vco_en` remain 1 on that edge.
- R3: `xtal_en` and `vco_en` fall exactly PARK_CYCLES reference cycles after the gate enables fell.
- R4: After `pd_req_n` returns high, `xtal_en` and `vco_en` rise with the R1 latency. The gate enables stay 0 for exactly WAKE_CYCLES further cycles and then reopen.
- R5: In the running state, `cpu_stop_n`=0 clears `cpu_clk_en` and `pci_stop_n`=0 clears `pci_clk_en`, each with the R1 latency. `free_clk_en` and `ref_clk_en` stay 1.
- R6: Outside the running state, the stop requests have no effect on any output.
- R7: If `pd_req_n` falls again during the stabilization interval, both oscillator enables drop with the R1 latency and the gates stay 0.
- R8: If `pd_req_n` rises during the parking interval, the entry sequence still completes. The oscillators switch off for exactly one cycle, and a full stabilization interval follows.
- R9: During reset, `xtal_en`=`vco_en`=1 and all gate enables are 0. After reset, the gates open only once a full WAKE_CYCLES interval has elapsed.
- R10: No gate enable is ever 1 while either oscillator enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_n | input | 1 | Asynchronous power-down request, active low |
| cpu_stop_n | input | 1 | Asynchronous CPU-group stop request, active low |
| pci_stop_n | input | 1 | Asynchronous PCI-group stop request, active low |
| xtal_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | VCO enable |
| cpu_clk_en | output | 1 | CPU output group gate enable |
| pci_clk_en | output | 1 | Stoppable PCI output group gate enable |
| free_clk_en | output | 1 | Free-running PCI and fixed-rate output gate enable |
| ref_clk_en | output | 1 | Reference output gate enable |

## Verification
The bench builds the block with WAKE_CYCLES=24, PARK_CYCLES=3 and SYNC_STAGES=2. With these values the full stabilization interval, including its last held cycle and its release edge, fits in a few dozen cycles. The three-cycle parking window is wide enough for a request to rise and fall inside it. The same short interval lets a power-down request land in the middle of a wake-up, and lets reset be released with the request already low, both in a short run.

// File: rtl/clkgen_pwrdn_pkg.sv
package clkgen_pwrdn_pkg;

   typedef enum logic [1:0] {
      ST_RUN     = 2'd0,
      ST_PARK    = 2'd1,
      ST_OSC_OFF = 2'd2,
      ST_WAKE    = 2'd3
   } pd_state_e;

   typedef struct packed {
      logic xtal;
      logic vco;
      logic cpu;
      logic pci;
      logic free;
      logic refc;
   } pd_enables_t;

   // Enable pattern for a given state; stop requests matter only in RUN.
   function automatic pd_enables_t pd_decode(pd_state_e st, logic cpu_go, logic pci_go);
      pd_enables_t e;
      e = '0;
      case (st)
         ST_RUN: begin
            e.xtal = 1'b1;
            e.vco  = 1'b1;
            e.cpu  = cpu_go;
            e.pci  = pci_go;
            e.free = 1'b1;
            e.refc = 1'b1;
         end
         ST_PARK, ST_WAKE: begin
            e.xtal = 1'b1;
            e.vco  = 1'b1;
         end
         default: e = '0;
      endcase
      return e;
   endfunction

endpackage

// File: rtl/pwrdn_sync.sv
module pwrdn_sync #(
   parameter int         WIDTH   = 1,
   parameter int         STAGES  = 2,
   parameter logic [0:0] RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   localparam logic [WIDTH-1:0] RST_VEC = {WIDTH{RST_VAL}};

   logic [WIDTH-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pwrdn_sync: STAGES must be at least 2");
      end
      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         if (k == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VEC;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[k] <= RST_VEC;
               else        chain[k] <= chain[k-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/pwrdn_timer.sv
module pwrdn_timer #(
   parameter int             CNT_W   = 8,
   parameter logic [CNT_W-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= RST_VAL;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/clkgen_pwrdn_seq.sv
module clkgen_pwrdn_seq
   import clkgen_pwrdn_pkg::*;
#(
   parameter int WAKE_CYCLES = 42954,
   parameter int PARK_CYCLES = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pd_req_n,
   input  logic cpu_stop_n,
   input  logic pci_stop_n,
   output logic xtal_en,
   output logic vco_en,
   output logic cpu_clk_en,
   output logic pci_clk_en,
   output logic free_clk_en,
   output logic ref_clk_en
);

   localparam int MAX_CNT = (WAKE_CYCLES > PARK_CYCLES) ? WAKE_CYCLES : PARK_CYCLES;
   localparam int CNT_W   = $clog2(MAX_CNT + 1);
   localparam logic [CNT_W-1:0] WAKE_LD = CNT_W'(WAKE_CYCLES - 1);
   localparam logic [CNT_W-1:0] PARK_LD = CNT_W'(PARK_CYCLES - 1);

   generate
      if (WAKE_CYCLES < 1) begin : g_bad_wake
         $error("clkgen_pwrdn_seq: WAKE_CYCLES must be at least 1");
      end
      if (PARK_CYCLES < 1) begin : g_bad_park
         $error("clkgen_pwrdn_seq: PARK_CYCLES must be at least 1");
      end
   endgenerate

   // Synchronized requests: [2] power-down, [1] cpu stop, [0] pci stop
   logic [2:0] req_s;

   pwrdn_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({pd_req_n, cpu_stop_n, pci_stop_n}),
      .q     (req_s)
   );

   logic pd_run_s;
   logic cpu_go_s;
   logic pci_go_s;
   assign pd_run_s = req_s[2];
   assign cpu_go_s = req_s[1];
   assign pci_go_s = req_s[0];

   pd_state_e        st_q, st_d;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_done;

   pwrdn_timer #(
      .CNT_W   (CNT_W),
      .RST_VAL (WAKE_LD)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_done)
   );

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = WAKE_LD;
      case (st_q)
         ST_RUN: begin
            if (!pd_run_s) begin
               st_d     = ST_PARK;
               tmr_load = 1'b1;
               tmr_val  = PARK_LD;
            end
         end
         ST_PARK: begin
            if (tmr_done) st_d = ST_OSC_OFF;
         end
         ST_OSC_OFF: begin
            if (pd_run_s) begin
               st_d     = ST_WAKE;
               tmr_load = 1'b1;
               tmr_val  = WAKE_LD;
            end
         end
         ST_WAKE: begin
            if (!pd_run_s)     st_d = ST_OSC_OFF;
            else if (tmr_done) st_d = ST_RUN;
         end
         default: st_d = ST_WAKE;
      endcase
   end

   pd_enables_t en_q;
   pd_enables_t en_rst;
   assign en_rst = pd_decode(ST_WAKE, 1'b0, 1'b0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_WAKE;
         en_q <= en_rst;
      end else begin
         st_q <= st_d;
         en_q <= pd_decode(st_d, cpu_go_s, pci_go_s);
      end
   end

   assign xtal_en     = en_q.xtal;
   assign vco_en      = en_q.vco;
   assign cpu_clk_en  = en_q.cpu;
   assign pci_clk_en  = en_q.pci;
   assign free_clk_en = en_q.free;
   assign ref_clk_en  = en_q.refc;

endmodule

// File: rtl/clkgen_pwrdn_seq_chk.sv
module clkgen_pwrdn_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic xtal_en,
   input logic vco_en,
   input logic cpu_clk_en,
   input logic pci_clk_en,
   input logic free_clk_en,
   input logic ref_clk_en
);

   logic any_gate;
   assign any_gate = cpu_clk_en | pci_clk_en | free_clk_en | ref_clk_en;

   assert_gates_need_osc_R10: assert property (@(posedge clk) disable iff (!rst_n)
      any_gate |-> (xtal_en && vco_en));

   assert_osc_off_after_park_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(xtal_en) |-> ($past(any_gate) == 1'b0));

   assert_gates_fall_together_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(free_clk_en) |-> (!cpu_clk_en && !pci_clk_en && !ref_clk_en && xtal_en && vco_en));

   assert_wake_holds_gates_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xtal_en) |-> !any_gate);

   assert_free_ref_unstopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
      free_clk_en == ref_clk_en);

   assert_osc_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
      xtal_en == vco_en);

endmodule

bind clkgen_pwrdn_seq clkgen_pwrdn_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .xtal_en     (xtal_en),
   .vco_en      (vco_en),
   .cpu_clk_en  (cpu_clk_en),
   .pci_clk_en  (pci_clk_en),
   .free_clk_en (free_clk_en),
   .ref_clk_en  (ref_clk_en)
);

// File: tb/clkgen_pwrdn_seq_bench.sv
`timescale 1ns/1ps
module clkgen_pwrdn_seq_bench;

   logic clk = 1'b0;
   logic rst_n;
   logic pd_req_n, cpu_stop_n, pci_stop_n;
   logic xtal_en, vco_en, cpu_clk_en, pci_clk_en, free_clk_en, ref_clk_en;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   clkgen_pwrdn_seq #(
      .WAKE_CYCLES (24),
      .PARK_CYCLES (3),
      .SYNC_STAGES (2)
   ) u_clkgen_pwrdn_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .pd_req_n    (pd_req_n),
      .cpu_stop_n  (cpu_stop_n),
      .pci_stop_n  (pci_stop_n),
      .xtal_en     (xtal_en),
      .vco_en      (vco_en),
      .cpu_clk_en  (cpu_clk_en),
      .pci_clk_en  (pci_clk_en),
      .free_clk_en (free_clk_en),
      .ref_clk_en  (ref_clk_en)
   );

   // Row: {pd,cpu_stop,pci_stop}[20:18] wait[17:10] expect{xtal,vco,cpu,pci,free,ref}[9:4] req[3:0]
   localparam int NVEC = 15;
   localparam logic [20:0] VEC [NVEC] = '{
      {3'b111, 8'd1,  6'b111111, 4'd5},   // R5 running baseline
      {3'b101, 8'd2,  6'b111111, 4'd1},   // R1 cpu stop not yet visible
      {3'b101, 8'd1,  6'b110111, 4'd5},   // R5 cpu gate closes
      {3'b100, 8'd3,  6'b110011, 4'd5},   // R5 pci gate closes too
      {3'b111, 8'd3,  6'b111111, 4'd5},   // R5 both reopen
      {3'b011, 8'd2,  6'b111111, 4'd1},   // R1 power-down not yet visible
      {3'b011, 8'd1,  6'b110000, 4'd2},   // R2 gates drop, osc on
      {3'b011, 8'd2,  6'b110000, 4'd3},   // R3 still parking
      {3'b011, 8'd1,  6'b000000, 4'd3},   // R3 osc off
      {3'b000, 8'd5,  6'b000000, 4'd6},   // R6 stops ignored while off
      {3'b100, 8'd2,  6'b000000, 4'd1},   // R1 release not yet visible
      {3'b100, 8'd1,  6'b110000, 4'd4},   // R4 osc back, gates held
      {3'b111, 8'd22, 6'b110000, 4'd6},   // R6 stops ignored while waking
      {3'b111, 8'd1,  6'b110000, 4'd4},   // R4 last held cycle
      {3'b111, 8'd1,  6'b111111, 4'd4}    // R4 gates reopen
   };

   function automatic logic [5:0] outs();
      return {xtal_en, vco_en, cpu_clk_en, pci_clk_en, free_clk_en, ref_clk_en};
   endfunction

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input int req, input logic [5:0] exp);
      logic [5:0] got;
      got = outs();
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL R%0d got=%b expected=%b at %0t", req, got, exp, $time);
      end
   endtask

   initial begin
      rst_n = 1'b0; pd_req_n = 1'b1; cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
      step(3);
      check(9, 6'b110000);                 // R9 reset state
      rst_n = 1'b1;
      step(23);
      check(9, 6'b110000);                 // R9 wake interval after reset
      step(1);
      check(9, 6'b111111);                 // R9 gates open

      for (int i = 0; i < NVEC; i++) begin
         {pd_req_n, cpu_stop_n, pci_stop_n} = VEC[i][20:18];
         step(int'(VEC[i][17:10]));
         check(int'(VEC[i][3:0]), VEC[i][9:4]);
      end

      // R7: power-down request arriving during the wake interval
      pd_req_n = 1'b0; step(6);
      check(3, 6'b000000);                 // R3
      pd_req_n = 1'b1; step(3);
      check(4, 6'b110000);                 // R4
      step(5);
      pd_req_n = 1'b0; step(2);
      check(7, 6'b110000);                 // R7 not yet
      step(1);
      check(7, 6'b000000);                 // R7 osc off again
      pd_req_n = 1'b1; step(27);
      check(4, 6'b111111);                 // R4 full recovery

      // R8: request released inside the parking window
      pd_req_n = 1'b0; step(3);
      check(2, 6'b110000);                 // R2
      pd_req_n = 1'b1; step(2);
      check(8, 6'b110000);                 // R8 still parking
      step(1);
      check(8, 6'b000000);                 // R8 osc off one cycle
      step(1);
      check(8, 6'b110000);                 // R8 waking
      step(23);
      check(8, 6'b110000);                 // R8 full interval held
      step(1);
      check(8, 6'b111111);                 // R8 reopened

      // R9: reset released with power-down already requested
      rst_n = 1'b0; pd_req_n = 1'b0; step(2);
      rst_n = 1'b1; step(2);
      check(1, 6'b110000);                 // R1 latency from reset
      step(1);
      check(9, 6'b000000);                 // R9 goes straight to off
      pd_req_n = 1'b1; step(27);
      check(9, 6'b111111);                 // R9

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired at %0t", $time);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule